// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a six-bit digital step attenuator that is programmed over a three-wire serial link: a serial clock, a data line and a latch-enable strobe. A client hands it an attenuation request, given as a count of 0.5 dB steps from 0 to 63, through a valid/ready handshake. The block turns that count into the attenuator's active-low switch code by inverting every bit. It shifts the code out most significant bit first and then pulses latch-enable so that the attenuator applies the new setting.

All serial timing comes from the faster system clock. Each minimum time is held as a parameter in nanoseconds and turned into a count of system-clock cycles, rounded up. The serial clock idles low, and data changes only on its falling edge, so data is held for a full half period on both sides of each rising edge. Latch-enable rises only after a settle time that follows the last rising edge, and it stays high for a minimum width. The block takes no new request until a minimum time has passed since the previous latch pulse began. A one-cycle done pulse marks the end of each transfer.

Top module: `stepAttnProgrammer`

## Requirements
- R1: While reset is held and in the first cycle after it, serClk, serData, latchEn and done are 0 and reqReady is 1.
- R2: Each transfer carries exactly WIDTH bits, the most significant first. The word captured on the rising edges of serClk equals the bitwise inverse of the accepted reqSteps, so a request of 0 sends 111111 and a request of 63 sends 000000.
- R3: Every high phase and every low phase of serClk lasts at least ceil(SCLK_PERIOD_NS / (2*SYS_PERIOD_NS)) cycles. With the default values this is 5 cycles, which keeps the serial clock at or below 10 MHz with a 50% duty cycle.
- R4: serData stays unchanged for at least ceil(DATA_SETUP_NS/SYS_PERIOD_NS) cycles before each rising edge of serClk and for at least ceil(DATA_HOLD_NS/SYS_PERIOD_NS) cycles after it. serData never changes while serClk is high.
- R5: latchEn rises only after exactly WIDTH serClk rising edges of the current transfer. It rises with serClk low and at least ceil(LE_SETUP_NS/SYS_PERIOD_NS) cycles after the final rising edge.
- R6: latchEn stays high for at least ceil(LE_WIDTH_NS/SYS_PERIOD_NS) cycles, which is 3 by default.
- R7: Successive rising edges of latchEn are at least ceil(LE_GAP_NS/SYS_PERIOD_NS) cycles apart, which is 63 by default.
- R8: reqReady goes low in the cycle after a handshake and stays low until the transfer's done pulse and the latch spacing time have both passed. The value on reqSteps after acceptance has no effect on the word sent.
- R9: done is high for exactly one cycle, and that is the cycle in which latchEn first reads low after being high.
- R10: serClk has no edge while latchEn is high, and it stays low whenever no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqSteps | input | WIDTH | Requested attenuation in 0.5 dB steps |
| reqReady | output | 1 | Block can accept a request |
| serClk | output | 1 | Serial clock to the attenuator |
| serData | output | 1 | Serial data to the attenuator |
| latchEn | output | 1 | Latch-enable strobe to the attenuator |
| done | output | 1 | One-cycle pulse when latchEn falls |

## Verification
The first data bit appears one cycle after the handshake edge. The first serClk rise follows a full half period later, and each later edge comes a half period after the one before it. latchEn rises the setup count after the final rising edge, done coincides with latchEn falling, and reqReady returns roughly the spacing count after latchEn rose. Rather than predicting absolute cycle numbers, the bench samples every output on the falling system-clock edge and measures the cycles between the events it sees. It compares each interval with the minimum derived from the nanosecond figures. It compares the word captured on the serClk rises with the inverted request once latchEn rises. reqReady is checked on every cycle from acceptance until done.

// File: rtl/stepAttnPkg.sv
package stepAttnPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LESU,
    ST_LEHI
  } seqState_t;

  // one-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic clkRise;
    logic clkFall;
    logic latchOn;
    logic latchOff;
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/stepAttnSequencer.sv
module stepAttnSequencer
  import stepAttnPkg::*;
#(
  parameter int WIDTH    = 6,
  parameter int HALF_CYC = 5,
  parameter int LESU_CYC = 1,
  parameter int LEPW_CYC = 3,
  parameter int GAP_CYC  = 63
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int TMR_MAX = maxOf(maxOf(HALF_CYC, LESU_CYC), LEPW_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(WIDTH + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  seqState_t          state;
  logic [TMR_W-1:0]   tmr;
  logic [BIT_W-1:0]   bitCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               tmrDone;

  assign tmrDone  = (tmr == '0);
  assign reqReady = (state == ST_IDLE) && (gapCnt == '0);

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && reqValid && reqReady;
    strobe.clkRise  = (state == ST_LOW)  && tmrDone;
    strobe.clkFall  = (state == ST_HIGH) && tmrDone;
    strobe.shift    = strobe.clkFall && (bitCnt != '0);
    strobe.latchOn  = (state == ST_LESU) && tmrDone;
    strobe.latchOff = (state == ST_LEHI) && tmrDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      bitCnt <= '0;
      gapCnt <= '0;
    end else begin
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (!tmrDone) tmr <= tmr - 1'b1;
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state  <= ST_LOW;
            tmr    <= TMR_W'(HALF_CYC - 1);
            bitCnt <= BIT_W'(WIDTH - 1);
          end
        end
        ST_LOW: begin
          if (tmrDone) begin
            state <= ST_HIGH;
            tmr   <= TMR_W'(HALF_CYC - 1);
          end
        end
        ST_HIGH: begin
          if (tmrDone) begin
            if (bitCnt == '0) begin
              state <= ST_LESU;
              tmr   <= TMR_W'(LESU_CYC - 1);
            end else begin
              state  <= ST_LOW;
              tmr    <= TMR_W'(HALF_CYC - 1);
              bitCnt <= bitCnt - 1'b1;
            end
          end
        end
        ST_LESU: begin
          if (tmrDone) begin
            state  <= ST_LEHI;
            tmr    <= TMR_W'(LEPW_CYC - 1);
            gapCnt <= GAP_W'(GAP_CYC - 1);
          end
        end
        ST_LEHI: begin
          if (tmrDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stepAttnShifter.sv
module stepAttnShifter
  import stepAttnPkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [WIDTH-1:0] reqSteps,
  output logic             serClk,
  output logic             serData,
  output logic             latchEn,
  output logic             done
);

  logic [WIDTH-1:0] switchCode;
  logic [WIDTH-1:0] shiftReg;

  // each switch is active low: a set step bit opens its stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_invert
    assign switchCode[i] = ~reqSteps[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      serClk   <= 1'b0;
      serData  <= 1'b0;
      latchEn  <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg <= switchCode;
        serData  <= switchCode[WIDTH-1];
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
        serData  <= shiftReg[WIDTH-2];
      end
      if (strobe.clkRise)      serClk <= 1'b1;
      else if (strobe.clkFall) serClk <= 1'b0;
      if (strobe.latchOn)       latchEn <= 1'b1;
      else if (strobe.latchOff) latchEn <= 1'b0;
      done <= strobe.latchOff;
    end
  end

endmodule

// File: rtl/stepAttnProgrammer.sv
module stepAttnProgrammer
  import stepAttnPkg::*;
#(
  parameter int WIDTH          = 6,
  parameter int SYS_PERIOD_NS  = 10,
  parameter int SCLK_PERIOD_NS = 100,
  parameter int DATA_SETUP_NS  = 10,
  parameter int DATA_HOLD_NS   = 10,
  parameter int LE_SETUP_NS    = 10,
  parameter int LE_WIDTH_NS    = 30,
  parameter int LE_GAP_NS      = 630
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [WIDTH-1:0] reqSteps,
  output logic             reqReady,
  output logic             serClk,
  output logic             serData,
  output logic             latchEn,
  output logic             done
);

  localparam int HALF_CYC = maxOf(maxOf(ceilDiv(SCLK_PERIOD_NS, 2 * SYS_PERIOD_NS), 1),
                                  maxOf(ceilDiv(DATA_SETUP_NS, SYS_PERIOD_NS),
                                        ceilDiv(DATA_HOLD_NS, SYS_PERIOD_NS)));
  localparam int LESU_CYC = maxOf(ceilDiv(LE_SETUP_NS, SYS_PERIOD_NS), 1);
  localparam int LEPW_CYC = maxOf(ceilDiv(LE_WIDTH_NS, SYS_PERIOD_NS), 1);
  localparam int GAP_CYC  = maxOf(ceilDiv(LE_GAP_NS, SYS_PERIOD_NS), 1);

  seqStrobe_t strobe;

  stepAttnSequencer #(
    .WIDTH   (WIDTH),
    .HALF_CYC(HALF_CYC),
    .LESU_CYC(LESU_CYC),
    .LEPW_CYC(LEPW_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  stepAttnShifter #(
    .WIDTH(WIDTH)
  ) u_shift (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqSteps(reqSteps),
    .serClk  (serClk),
    .serData (serData),
    .latchEn (latchEn),
    .done    (done)
  );

endmodule

// File: rtl/stepAttnChecker.sv
module stepAttnChecker #(
  parameter int HALF_CYC = 5,
  parameter int LESU_CYC = 1,
  parameter int LEPW_CYC = 3,
  parameter int GAP_CYC  = 63
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic serClk,
  input logic serData,
  input logic latchEn,
  input logic done
);

  localparam logic [15:0] SAT = 16'hFFFF;

  logic        clkQ;
  logic        leQ;
  logic [15:0] hiCnt;
  logic [15:0] loCnt;
  logic [15:0] leCnt;
  logic [15:0] sinceRise;
  logic [15:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ      <= 1'b0;
      leQ       <= 1'b0;
      hiCnt     <= '0;
      loCnt     <= '0;
      leCnt     <= '0;
      sinceRise <= SAT;
      gapCnt    <= SAT;
    end else begin
      clkQ      <= serClk;
      leQ       <= latchEn;
      hiCnt     <= serClk  ? ((hiCnt == SAT) ? SAT : hiCnt + 1'b1) : '0;
      loCnt     <= !serClk ? ((loCnt == SAT) ? SAT : loCnt + 1'b1) : '0;
      leCnt     <= latchEn ? ((leCnt == SAT) ? SAT : leCnt + 1'b1) : '0;
      sinceRise <= (serClk && !clkQ) ? 16'd1 :
                   ((sinceRise == SAT) ? SAT : sinceRise + 1'b1);
      gapCnt    <= (latchEn && !leQ) ? 16'd1 :
                   ((gapCnt == SAT) ? SAT : gapCnt + 1'b1);
    end
  end

  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> hiCnt >= 16'(HALF_CYC)); // R3
  AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> loCnt >= 16'(HALF_CYC)); // R3
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serData)); // R4
  AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEn) |-> (!serClk && sinceRise >= 16'(LESU_CYC))); // R5
  AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchEn) |-> leCnt >= 16'(LEPW_CYC)); // R6
  AST_LATCH_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEn) |-> gapCnt >= 16'(GAP_CYC)); // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!latchEn && !serClk)); // R8
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(latchEn)); // R9
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchEn) |-> done); // R9
  AST_NO_CLK_IN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> (!serClk && $stable(serClk))); // R10

endmodule

bind stepAttnProgrammer stepAttnChecker #(
  .HALF_CYC(HALF_CYC),
  .LESU_CYC(LESU_CYC),
  .LEPW_CYC(LEPW_CYC),
  .GAP_CYC (GAP_CYC)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .serClk  (serClk),
  .serData (serData),
  .latchEn (latchEn),
  .done    (done)
);

// File: tb/test_stepAttnProgrammer.sv
module test_stepAttnProgrammer;

  localparam int W     = 6;
  localparam int P_NS  = 10;
  localparam int WDOG  = 150000;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  localparam int HALF_MIN = cdiv(100, 2 * P_NS);
  localparam int SU_MIN   = cdiv(10, P_NS);
  localparam int HD_MIN   = cdiv(10, P_NS);
  localparam int LESU_MIN = cdiv(10, P_NS);
  localparam int LEPW_MIN = cdiv(30, P_NS);
  localparam int GAP_MIN  = cdiv(630, P_NS);

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [W-1:0] reqSteps;
  logic         reqReady;
  logic         serClk;
  logic         serData;
  logic         latchEn;
  logic         done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] expSteps = '0;

  always #5 clk = ~clk;

  stepAttnProgrammer i_stepAttnProgrammer (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqSteps(reqSteps),
    .reqReady(reqReady),
    .serClk  (serClk),
    .serData (serData),
    .latchEn (latchEn),
    .done    (done)
  );

  function automatic logic [W-1:0] expectedCode(input logic [W-1:0] steps);
    return ~steps;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // protocol monitor, sampled between clock edges
  logic pClk = 1'b0, pData = 1'b0, pLe = 1'b0, seenLe = 1'b0;
  int sdStable = 1000, sinceRise = 1000, hiCnt = 0, loCnt = 1000;
  int leHiCnt = 0, sinceLeRise = 1000, bitCnt = 0;
  logic [W-1:0] word = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serData != pData) begin
        check(!serClk, "R4 change while clock high", int'(serClk), 0);
        check(sinceRise >= HD_MIN, "R4 hold", sinceRise, HD_MIN);
        sdStable = 1;
      end else begin
        sdStable++;
      end
      if (serClk && !pClk) begin
        check(loCnt >= HALF_MIN, "R3 low phase", loCnt, HALF_MIN);
        check(sdStable - 1 >= SU_MIN, "R4 setup", sdStable - 1, SU_MIN);
        check(!latchEn, "R10 edge during latch", int'(latchEn), 0);
        word = {word[W-2:0], serData};
        bitCnt++;
        sinceRise = 0;
        hiCnt = 1;
      end else if (!serClk && pClk) begin
        check(hiCnt >= HALF_MIN, "R3 high phase", hiCnt, HALF_MIN);
        check(!latchEn, "R10 edge during latch", int'(latchEn), 0);
        loCnt = 1;
      end else if (serClk) begin
        hiCnt++;
      end else begin
        loCnt++;
      end
      if (latchEn && !pLe) begin
        check(bitCnt == W, "R5 bit count", bitCnt, W);
        check(sinceRise >= LESU_MIN, "R5 latch setup", sinceRise, LESU_MIN);
        check(!serClk, "R5 clock low at latch", int'(serClk), 0);
        check(word == expectedCode(expSteps), "R2 word", int'(word), int'(expectedCode(expSteps)));
        if (seenLe) check(sinceLeRise >= GAP_MIN, "R7 latch spacing", sinceLeRise, GAP_MIN);
        seenLe = 1'b1;
        bitCnt = 0;
        word = '0;
        sinceLeRise = 0;
        leHiCnt = 1;
      end else if (latchEn) begin
        leHiCnt++;
      end
      if (!latchEn && pLe) begin
        check(leHiCnt >= LEPW_MIN, "R6 latch width", leHiCnt, LEPW_MIN);
        check(done, "R9 done at latch fall", int'(done), 1);
      end else if (done) begin
        check(1'b0, "R9 stray done", int'(done), 0);
      end
      sinceRise++;
      sinceLeRise++;
      pClk = serClk;
      pData = serData;
      pLe = latchEn;
    end
  end

  task automatic send(input logic [W-1:0] s);
    @(negedge clk);
    reqValid = 1'b1;
    reqSteps = s;
    expSteps = s;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqSteps = W'($urandom);
    check(!reqReady, "R8 ready after accept", int'(reqReady), 0);
    while (!done) begin
      @(negedge clk);
      reqSteps = W'($urandom);
      check(!reqReady, "R8 ready while busy", int'(reqReady), 0);
    end
    check(!serClk, "R10 clock idles low", int'(serClk), 0);
  endtask

  task automatic runAll();
    int unsigned seed;
    seed = $urandom(32'h5EED_A77E);
    rstN = 1'b0;
    reqValid = 1'b0;
    reqSteps = '0;
    repeat (3) @(negedge clk);
    check(!serClk && !serData && !latchEn && !done, "R1 outputs in reset",
          int'({serClk, serData, latchEn, done}), 0);
    check(reqReady, "R1 ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(!serClk && !latchEn && !done && reqReady, "R1 after reset",
          int'({serClk, latchEn, done, reqReady}), 1);
    // directed corners: all steps off, all on, alternating, single bits
    send(6'd0);
    send(6'd63);
    send(6'h2A);
    send(6'h15);
    send(6'h01);
    send(6'h20);
    for (int i = 0; i < 40; i++) begin
      repeat ($urandom % 4) @(negedge clk);
      send(W'($urandom));
    end
    repeat (80) @(negedge clk);
    check(reqReady && !serClk && !latchEn, "R8 idle ready at end",
          int'({reqReady, serClk, latchEn}), 4);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WDOG) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule